// File: doc/BRIEF.md
# Three-Sample Bang-Bang Phase Detector with Vote Averaging

This block forms the digital back end of a clock and data recovery loop. Per bit interval the front end delivers two sampled bits. One is taken at the bit centre. The other is taken at the crossover between the previous bit and the current one. The block keeps the previous centre sample in a register, so each interval can be judged from three aligned samples: previous bit, crossover and current bit. Each interval is classified as early, late or indeterminate. The register holding the previous centre sample is also the retimed data output, so the decision flop sits inside the phase loop.

Votes are not sent to the oscillator control one by one. They are summed in a saturating signed accumulator over a window of `WIN_LEN` classified intervals. At the close of each window the block presents the sum and raises at most one correction pulse: up when the sum is above `THR`, down when it is below `-THR`. The accumulator then restarts from zero. Running counts of early, late and indeterminate intervals are brought out for observation.

A small controller with two states orders this. PRIME is entered on reset. In PRIME the next valid interval only loads the previous-sample register, because no earlier bit exists yet. The transition "first bit" then moves the controller to TRACK. In TRACK every valid interval is classified and voted. Reset is the only way back to PRIME.

Top module: `phase_vote_detector`

## Requirements
- R1: One clock after an edge where `smp_valid` is high, `data_out` equals the centre sample taken at that edge and `data_valid` is high for exactly that one cycle.
- R2: In TRACK, when the previous bit and the current centre bit differ and the crossover sample equals the previous bit, the interval is early: `cnt_early` rises by one and the vote is -1.
- R3: In TRACK, when the previous bit and the current centre bit differ and the crossover sample equals the current bit, the interval is late: `cnt_late` rises by one and the vote is +1.
- R4: In TRACK, when the previous bit equals the current centre bit, the interval is indeterminate: `cnt_idle` rises by one and the vote is 0, but the interval still counts toward the window.
- R5: The first valid interval after reset (state PRIME) only loads the previous-sample register. It changes no counter, casts no vote, does not count toward the window and raises no pulse.
- R6: The running sum saturates at +(2^(ACC_W-1)-1) and -(2^(ACC_W-1)-1) and never wraps.
- R7: On the clock after the last of every `WIN_LEN` classified intervals, `avg_valid` pulses for one cycle and `avg_sum` (two's complement) holds that window's sum. `pd_up` pulses with it if the sum is greater than `THR`, `pd_dn` pulses with it if the sum is less than `-THR`, and neither pulses otherwise. The next window starts from zero.
- R8: A cycle with `smp_valid` low changes no output other than dropping the one-cycle pulses.
- R9: A synchronous active-high `rst` clears the sum, the window position, the counters, the retimed data and all pulses, and returns the controller to PRIME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate or word-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One bit interval's samples are present |
| smp_center | input | 1 | Sample taken at the bit centre |
| smp_cross | input | 1 | Sample taken at the crossover before this bit |
| data_out | output | 1 | Retimed data bit (previous centre sample) |
| data_valid | output | 1 | One-cycle strobe for a new `data_out` |
| pd_up | output | 1 | Clock-late correction pulse at window close |
| pd_dn | output | 1 | Clock-early correction pulse at window close |
| avg_valid | output | 1 | One-cycle strobe marking a closed window |
| avg_sum | output | ACC_W | Signed sum of the last closed window |
| cnt_early | output | CNT_W | Early intervals since reset (wraps) |
| cnt_late | output | CNT_W | Late intervals since reset (wraps) |
| cnt_idle | output | CNT_W | Indeterminate intervals since reset (wraps) |

## Verification
The bench builds the block with `WIN_LEN` = 8, `ACC_W` = 4 and `THR` = 2. With these values the saturation limit of ±7 is reached inside a single window of eight identical votes, and window sums of exactly 2, 3, -2 and -3 sit on both sides of the threshold and take only a few intervals to build. All eight combinations of previous bit, crossover and current bit are swept. The bench also runs long runs of each vote kind, a pseudo-random mix and a reset in the middle of a window, and it toggles the sample inputs while `smp_valid` is low.

// File: rtl/pvote_pkg.sv
package pvote_pkg;

    // Outcome of judging one bit interval
    typedef enum logic [1:0] {
        VOTE_NONE  = 2'd0,   // no classified interval this cycle
        VOTE_EARLY = 2'd1,
        VOTE_LATE  = 2'd2,
        VOTE_IDLE  = 2'd3    // no transition, indeterminate
    } vote_t;

    // Controller states
    typedef enum logic {
        ST_PRIME = 1'b0,     // waiting for the first bit after reset
        ST_TRACK = 1'b1      // classifying every valid interval
    } pd_state_t;

endpackage

// File: rtl/pvote_sampler.sv
module pvote_sampler (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic smp_center,
    output logic bit_q,
    output logic bit_valid
);

    // The decision flop: holds the previous centre sample, doubles as retimed data
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q     <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= smp_valid;
            if (smp_valid) begin
                bit_q <= smp_center;
            end
        end
    end

endmodule

// File: rtl/pvote_classify.sv
module pvote_classify
    import pvote_pkg::*;
(
    input  logic  en,
    input  logic  bit_prev,
    input  logic  bit_cross,
    input  logic  bit_cur,
    output vote_t vote
);

    always_comb begin
        if (!en) begin
            vote = VOTE_NONE;
        end else if (bit_prev == bit_cur) begin
            vote = VOTE_IDLE;
        end else if (bit_cross == bit_prev) begin
            vote = VOTE_EARLY;
        end else begin
            vote = VOTE_LATE;
        end
    end

endmodule

// File: rtl/pvote_accum.sv
module pvote_accum
    import pvote_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int ACC_W   = 6,
    parameter int THR     = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  vote_t                   vote,
    output logic                    pd_up,
    output logic                    pd_dn,
    output logic                    avg_valid,
    output logic signed [ACC_W-1:0] avg_sum
);

    localparam int WC_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam int SAT  = (2 ** (ACC_W - 1)) - 1;
    localparam logic signed [ACC_W:0]   SAT_HI = (ACC_W + 1)'(SAT);
    localparam logic signed [ACC_W:0]   SAT_LO = -SAT_HI;
    localparam logic signed [ACC_W:0]   THR_V  = (ACC_W + 1)'(THR);
    localparam logic [WC_W-1:0]         WC_END = WC_W'(WIN_LEN - 1);
    localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'(SAT);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_nxt;
    logic signed [ACC_W:0]   wide;
    logic signed [ACC_W:0]   delta;
    logic signed [ACC_W:0]   nxt_ext;
    logic [WC_W-1:0]         win_q;
    logic                    step;

    assign step = (vote != VOTE_NONE);

    always_comb begin
        unique case (vote)
            VOTE_EARLY: delta = -(ACC_W + 1)'(1);
            VOTE_LATE:  delta =  (ACC_W + 1)'(1);
            default:    delta = '0;
        endcase
        wide = $signed({acc_q[ACC_W-1], acc_q}) + delta;
        if (wide > SAT_HI) begin
            acc_nxt = SAT_HI[ACC_W-1:0];
        end else if (wide < SAT_LO) begin
            acc_nxt = SAT_LO[ACC_W-1:0];
        end else begin
            acc_nxt = wide[ACC_W-1:0];
        end
        nxt_ext = $signed({acc_nxt[ACC_W-1], acc_nxt});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            win_q     <= '0;
            avg_sum   <= '0;
            avg_valid <= 1'b0;
            pd_up     <= 1'b0;
            pd_dn     <= 1'b0;
        end else begin
            avg_valid <= 1'b0;
            pd_up     <= 1'b0;
            pd_dn     <= 1'b0;
            if (step) begin
                if (win_q == WC_END) begin
                    avg_sum   <= acc_nxt;
                    avg_valid <= 1'b1;
                    pd_up     <= (nxt_ext > THR_V);
                    pd_dn     <= (nxt_ext < -THR_V);
                    acc_q     <= '0;
                    win_q     <= '0;
                end else begin
                    acc_q <= acc_nxt;
                    win_q <= win_q + 1'b1;
                end
            end
        end
    end

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_MAX && vote == VOTE_LATE) |=> (acc_q == ACC_MAX || acc_q == '0));

    // R7
    up_dn_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pd_up && pd_dn));

    // R7
    pulse_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (pd_up || pd_dn) |-> avg_valid);

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> !avg_valid);

endmodule

// File: rtl/pvote_tally.sv
module pvote_tally
    import pvote_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  vote_t            vote,
    output logic [CNT_W-1:0] cnt_early,
    output logic [CNT_W-1:0] cnt_late,
    output logic [CNT_W-1:0] cnt_idle
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_early <= '0;
            cnt_late  <= '0;
            cnt_idle  <= '0;
        end else begin
            unique case (vote)
                VOTE_EARLY: cnt_early <= cnt_early + 1'b1;
                VOTE_LATE:  cnt_late  <= cnt_late + 1'b1;
                VOTE_IDLE:  cnt_idle  <= cnt_idle + 1'b1;
                default:    ;
            endcase
        end
    end

    // R2 R3 R4
    one_class_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({cnt_early != $past(cnt_early),
                    cnt_late  != $past(cnt_late),
                    cnt_idle  != $past(cnt_idle)}) <= 1);

endmodule

// File: rtl/phase_vote_detector.sv
module phase_vote_detector
    import pvote_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int ACC_W   = 6,
    parameter int THR     = 3,
    parameter int CNT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic                    smp_center,
    input  logic                    smp_cross,
    output logic                    data_out,
    output logic                    data_valid,
    output logic                    pd_up,
    output logic                    pd_dn,
    output logic                    avg_valid,
    output logic signed [ACC_W-1:0] avg_sum,
    output logic [CNT_W-1:0]        cnt_early,
    output logic [CNT_W-1:0]        cnt_late,
    output logic [CNT_W-1:0]        cnt_idle
);

    pd_state_t state_q;
    pd_state_t state_d;
    logic      vote_en;
    vote_t     vote;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and controller outputs
    always_comb begin
        state_d = state_q;
        vote_en = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                if (smp_valid) begin
                    state_d = ST_TRACK;   // first bit
                end
            end
            ST_TRACK: begin
                vote_en = smp_valid;
            end
            default: state_d = ST_PRIME;
        endcase
    end

    pvote_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_center (smp_center),
        .bit_q      (data_out),
        .bit_valid  (data_valid)
    );

    pvote_classify u_classify (
        .en        (vote_en),
        .bit_prev  (data_out),
        .bit_cross (smp_cross),
        .bit_cur   (smp_center),
        .vote      (vote)
    );

    pvote_accum #(
        .WIN_LEN (WIN_LEN),
        .ACC_W   (ACC_W),
        .THR     (THR)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .vote      (vote),
        .pd_up     (pd_up),
        .pd_dn     (pd_dn),
        .avg_valid (avg_valid),
        .avg_sum   (avg_sum)
    );

    pvote_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk       (clk),
        .rst       (rst),
        .vote      (vote),
        .cnt_early (cnt_early),
        .cnt_late  (cnt_late),
        .cnt_idle  (cnt_idle)
    );

    // R1
    retime_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (data_out == $past(smp_center)));

    // R5
    prime_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRIME && smp_valid) |=>
            (!avg_valid && $stable(cnt_early) && $stable(cnt_late) && $stable(cnt_idle)));

    // R8
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> (!data_valid && !avg_valid && $stable(data_out) &&
                        $stable(cnt_early) && $stable(cnt_late) && $stable(cnt_idle)));

endmodule

// File: tb/test_phase_vote_detector.sv
module test_phase_vote_detector;

    localparam int WIN = 8;
    localparam int AW  = 4;
    localparam int TH  = 2;
    localparam int CW  = 16;
    localparam int LIM = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic smp_center = 1'b0;
    logic smp_cross = 1'b0;
    logic data_out, data_valid, pd_up, pd_dn, avg_valid;
    logic signed [AW-1:0] avg_sum;
    logic [CW-1:0] cnt_early, cnt_late, cnt_idle;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    bit m_first = 1'b1;
    bit m_prev  = 1'b0;
    int m_acc = 0, m_wc = 0, m_e = 0, m_l = 0, m_i = 0;
    logic [7:0] lfsr = 8'hA5;

    always #2 clk = ~clk;

    phase_vote_detector #(.WIN_LEN(WIN), .ACC_W(AW), .THR(TH), .CNT_W(CW)) i_phase_vote_detector (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_center(smp_center),
        .smp_cross(smp_cross), .data_out(data_out), .data_valid(data_valid),
        .pd_up(pd_up), .pd_dn(pd_dn), .avg_valid(avg_valid), .avg_sum(avg_sum),
        .cnt_early(cnt_early), .cnt_late(cnt_late), .cnt_idle(cnt_idle)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_counts();
        chk("R2 early count", int'(cnt_early), m_e);
        chk("R3 late count", int'(cnt_late), m_l);
        chk("R4 idle count", int'(cnt_idle), m_i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_first = 1'b1; m_prev = 1'b0; m_acc = 0; m_wc = 0; m_e = 0; m_l = 0; m_i = 0;
        chk("R9 data_out cleared", int'(data_out), 0);
        chk("R9 pulses cleared", int'({pd_up, pd_dn, avg_valid, data_valid}), 0);
        chk("R9 sum cleared", int'(avg_sum), 0);
        check_counts();
    endtask

    task automatic send(bit b, bit c);
        bit ev = 1'b0;
        int sum = 0;
        bit was_first;
        @(negedge clk);
        smp_valid = 1'b1; smp_cross = b; smp_center = c;
        @(negedge clk);
        smp_valid = 1'b0; smp_cross = ~b; smp_center = ~c;
        was_first = m_first;
        if (m_first) begin
            m_first = 1'b0;
        end else begin
            if (m_prev == c) m_i++;
            else if (b == m_prev) begin m_e++; m_acc--; end
            else begin m_l++; m_acc++; end
            if (m_acc > LIM) m_acc = LIM;
            if (m_acc < -LIM) m_acc = -LIM;
            m_wc++;
            if (m_wc == WIN) begin
                ev = 1'b1; sum = m_acc; m_acc = 0; m_wc = 0;
            end
        end
        m_prev = c;
        chk("R1 retimed data", int'(data_out), int'(c));
        chk("R1 data strobe", int'(data_valid), 1);
        check_counts();
        if (was_first) chk("R5 prime casts no vote", int'(avg_valid), 0);
        chk("R7 window strobe", int'(avg_valid), int'(ev));
        chk("R7 up pulse", int'(pd_up), int'(ev && sum > TH));
        chk("R7 down pulse", int'(pd_dn), int'(ev && sum < -TH));
        if (ev) chk("R6 R7 window sum", int'(avg_sum), sum);
        @(negedge clk);
        chk("R8 gap holds data", int'(data_out), int'(c));
        chk("R8 gap drops pulses", int'({pd_up, pd_dn, avg_valid, data_valid}), 0);
        check_counts();
    endtask

    // kind: 0 early, 1 late, 2 idle
    task automatic send_kind(int kind, bit junk);
        if (kind == 0)      send(m_prev, ~m_prev);
        else if (kind == 1) send(~m_prev, ~m_prev);
        else                send(junk, m_prev);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        // R5: first interval after reset only loads the previous bit
        send(1'b1, 1'b0);
        chk("R5 prime counters", int'(cnt_early) + int'(cnt_late) + int'(cnt_idle), 0);

        // exhaustive over all (previous, crossover, current) triples: R2 R3 R4
        for (int rep = 0; rep < 2; rep++) begin
            for (int t = 0; t < 8; t++) begin
                send(1'b0, t[2]);
                send(t[1], t[0]);
            end
        end

        // late run reaches positive saturation: R6
        do_reset();
        send(1'b0, 1'b0);
        for (int k = 0; k < 3 * WIN; k++) send_kind(1, 1'b0);

        // early run reaches negative saturation: R6
        do_reset();
        send(1'b0, 1'b1);
        for (int k = 0; k < 3 * WIN; k++) send_kind(0, 1'b0);

        // idle only: sum 0, no pulses: R4
        do_reset();
        send(1'b0, 1'b1);
        for (int k = 0; k < 2 * WIN; k++) send_kind(2, k[0]);

        // threshold edges: sums 2, 3, -2, -3: R7
        for (int s = 0; s < 4; s++) begin
            do_reset();
            send(1'b1, 1'b0);
            for (int k = 0; k < WIN; k++) begin
                if (k < ((s % 2 == 0) ? 2 : 3)) send_kind((s < 2) ? 1 : 0, 1'b0);
                else send_kind(2, 1'b1);
            end
        end

        // balanced alternation
        do_reset();
        send(1'b0, 1'b0);
        for (int k = 0; k < 2 * WIN; k++) send_kind(k % 2, 1'b0);

        // reset mid-window then prime again: R9 R5
        for (int k = 0; k < 5; k++) send_kind(1, 1'b0);
        do_reset();
        send(1'b1, 1'b1);
        chk("R5 prime after mid reset", int'(cnt_late), 0);

        // pseudo-random mix
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send(lfsr[0], lfsr[1]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule